// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-visible register file that manages a small translation lookaside buffer. It holds the tag, data and owner-ID storage of every entry. Software reaches that storage through a handful of registers on a simple register bus. An index register selects one entry. Two window registers move that entry's data word and tag word. A process-ID register supplies the owner ID that is recorded into an entry. A zone-protection register holds protection overrides. Writing a search register starts a lookup, and the result lands in the index register.

The match logic itself is an external comparator. During a search, this block steps through the entries one per cycle and presents each entry to the comparator, together with the search address, the current process ID, the zone register and the privilege level. The comparator answers with a same-cycle hit flag. A change of process ID also steps through the entries, this time to raise invalidate requests for mappings that belonged to the old ID. Changing the zone register raises a global flush pulse. Static configuration pins decide which accesses are permitted.

Requests use a valid/ready handshake. `req_ready` is low for the whole of a scan, so a request that is held valid waits until the scan finishes and is then taken. An accepted read returns `rsp_valid` with its data exactly one cycle later. That response path has no back-pressure.

Top module: `tlbreg_ctl`

## Requirements
- R1: After reset the index, process-ID and zone registers and all entries read as zero; `busy`, `rsp_valid`, `inval_valid` and `flush_pulse` are low and `req_ready` is high.
- R2: While `cfg_level` is below 2 or `cfg_access` is 0, every read returns 0 and every write changes no state.
- R3: The register map is: 0 index, 1 data window, 2 tag window, 3 process ID, 4 zone, 5 search. The entry selected for both windows is given by the low log2(ENTRIES) bits of the index register, and higher index bits do not affect the selection. Each window writes and reads back its own 32-bit word of that entry.
- R4: A tag-window write stores the low 8 bits of the process-ID register as the entry's owner ID. A permitted tag-window read copies the entry's owner ID into the process-ID register.
- R5: A tag-window write whose entry's old tag has bit 6 (valid) set produces a one-cycle `inval_valid` in the cycle after acceptance, carrying the old tag and the entry number. It produces nothing if the old tag is not valid.
- R6: Reads of the data window, tag window, process ID and zone return 0 unless `cfg_access` bit 0 is set. Index reads need only the global enable of R2.
- R7: Writes to the process ID, zone and search registers take effect only when `cfg_access` is 2 or 3. Index and window writes need only the global enable.
- R8: A search write looks up the written value with bits 9:0 cleared. It offers entries to the comparator in ascending order. The first hit loads the index register with that entry number. If no entry hits, bit 31 of the index register is set and its other bits are kept.
- R9: A zone write whose value differs from the current one gives a one-cycle `flush_pulse` in the cycle after acceptance. Rewriting the same value gives none.
- R10: A process-ID write whose low 8 bits differ from the current ID scans all entries. It raises `inval_valid` for every entry whose tag is valid and whose owner ID is nonzero and equal to the old ID. Writing the same ID starts no scan.
- R11: A search or an ID-change scan holds `busy` high, and `req_ready` low, until it ends. A search that misses keeps `busy` for exactly ENTRIES cycles.
- R12: Reads of addresses 5, 6 and 7 return 0; writes to 6 and 7 change nothing.
- R13: An accepted read gives `rsp_valid` with its data one cycle later. An accepted write never gives `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_level | input | 2 | Translation configuration level; below 2 disables the block |
| cfg_access | input | 2 | Register access configuration; 0 disables, bit 0 allows protected reads, 2 or more allows control writes |
| cur_user | input | 1 | Current privilege is user, passed to the comparator |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted when high; low while busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| busy | output | 1 | A scan is in progress |
| lk_valid | output | 1 | An entry is offered to the comparator this cycle |
| lk_idx | output | log2(ENTRIES) | Entry number being offered |
| lk_vaddr | output | 32 | Search address, bits 9:0 zero |
| lk_tag | output | 32 | Offered entry tag word |
| lk_data | output | 32 | Offered entry data word |
| lk_tid | output | 8 | Offered entry owner ID |
| lk_pid | output | 8 | Current process ID |
| lk_zpr | output | 32 | Current zone register |
| lk_user | output | 1 | Privilege for the lookup |
| lk_hit | input | 1 | Comparator hit for the offered entry, same cycle |
| inval_valid | output | 1 | Invalidate request pulse |
| inval_idx | output | log2(ENTRIES) | Entry of the invalidated mapping |
| inval_tag | output | 32 | Tag of the invalidated mapping |
| flush_pulse | output | 1 | Global flush request pulse |

## Verification
The bench targets a search that misses. A design that cleared the index or overwrote its low bits would read back something other than the old index with only bit 31 added. It checks ID changes against entries whose owner ID is zero and against entries that are not valid. A design that skipped either test would show stray invalidates in the recorded entry mask. It checks that a tag-window read refused by `cfg_access` leaves the process ID alone; a design that copied the ID first and checked permission afterwards would change the ID. It also checks for a repeated zone value and for the stale-tag invalidate on a tag write. Getting these wrong would give flushes or invalidates that are missing, duplicated, or carry the new tag instead of the old one.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;

  localparam int ADDR_W        = 3;
  localparam int TAG_VALID_BIT = 6;   // tag word: valid flag, decoded by the comparator
  localparam int EPN_LSB       = 10;  // tag word: page number starts here

  typedef enum logic [ADDR_W-1:0] {
    RA_INDEX  = 3'd0,
    RA_DATA   = 3'd1,
    RA_TAG    = 3'd2,
    RA_PID    = 3'd3,
    RA_ZONE   = 3'd4,
    RA_SEARCH = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SCAN_IDLE   = 2'd0,
    SCAN_SEARCH = 2'd1,
    SCAN_OWNER  = 2'd2
  } scan_mode_e;

endpackage

// File: rtl/tlbreg_access.sv
module tlbreg_access
  import tlbreg_pkg::*;
(
  input  logic [1:0]        cfg_level,
  input  logic [1:0]        cfg_access,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_ok,
  output logic              wr_ok
);

  logic enabled;
  logic rd_guarded;
  logic wr_guarded;

  always_comb begin
    enabled    = (cfg_level >= 2'd2) && (cfg_access != 2'd0);
    rd_guarded = enabled && cfg_access[0];
    wr_guarded = enabled && (cfg_access > 2'd1);
    rd_ok      = 1'b0;
    wr_ok      = 1'b0;
    case (addr)
      RA_INDEX:  begin rd_ok = enabled;    wr_ok = enabled;    end
      RA_DATA:   begin rd_ok = rd_guarded; wr_ok = enabled;    end
      RA_TAG:    begin rd_ok = rd_guarded; wr_ok = enabled;    end
      RA_PID:    begin rd_ok = rd_guarded; wr_ok = wr_guarded; end
      RA_ZONE:   begin rd_ok = rd_guarded; wr_ok = wr_guarded; end
      RA_SEARCH: begin rd_ok = 1'b0;       wr_ok = wr_guarded; end
      default:   begin rd_ok = 1'b0;       wr_ok = 1'b0;       end
    endcase
  end

endmodule

// File: rtl/tlbreg_store.sv
module tlbreg_store #(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 32,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tag,
  input  logic              wr_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [IDX_W-1:0]  bus_idx,
  output logic [WORD_W-1:0] bus_tag,
  output logic [WORD_W-1:0] bus_data,
  output logic [TID_W-1:0]  bus_tid,
  input  logic [IDX_W-1:0]  scan_idx,
  output logic [WORD_W-1:0] scan_tag,
  output logic [WORD_W-1:0] scan_data,
  output logic [TID_W-1:0]  scan_tid
);

  logic [WORD_W-1:0] tag_mem  [ENTRIES];
  logic [WORD_W-1:0] data_mem [ENTRIES];
  logic [TID_W-1:0]  tid_mem  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tag_mem[e]  <= '0;
        data_mem[e] <= '0;
        tid_mem[e]  <= '0;
      end
    end else begin
      if (wr_tag) begin
        tag_mem[wr_idx] <= wr_word;
        tid_mem[wr_idx] <= wr_tid;
      end
      if (wr_data) begin
        data_mem[wr_idx] <= wr_word;
      end
    end
  end

  assign bus_tag   = tag_mem[bus_idx];
  assign bus_data  = data_mem[bus_idx];
  assign bus_tid   = tid_mem[bus_idx];
  assign scan_tag  = tag_mem[scan_idx];
  assign scan_data = data_mem[scan_idx];
  assign scan_tid  = tid_mem[scan_idx];

endmodule

// File: rtl/tlbreg_scan.sv
module tlbreg_scan
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_search,
  input  logic             start_owner,
  input  logic [TID_W-1:0] owner_before,
  input  logic             lk_hit,
  input  logic             ent_valid,
  input  logic [TID_W-1:0] ent_tid,
  output scan_mode_e       mode,
  output logic [IDX_W-1:0] cnt,
  output logic             busy,
  output logic             hit_now,
  output logic             miss_now,
  output logic             inval_now
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [TID_W-1:0] old_owner;
  logic             at_last;

  always_comb begin
    at_last   = (cnt == LAST);
    busy      = (mode != SCAN_IDLE);
    hit_now   = (mode == SCAN_SEARCH) && lk_hit;
    miss_now  = (mode == SCAN_SEARCH) && !lk_hit && at_last;
    inval_now = (mode == SCAN_OWNER) && ent_valid &&
                (ent_tid != '0) && (ent_tid == old_owner);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= SCAN_IDLE;
      cnt       <= '0;
      old_owner <= '0;
    end else if (start_search) begin
      mode <= SCAN_SEARCH;
      cnt  <= '0;
    end else if (start_owner) begin
      mode      <= SCAN_OWNER;
      cnt       <= '0;
      old_owner <= owner_before;
    end else if (mode != SCAN_IDLE) begin
      if (hit_now || at_last) begin
        mode <= SCAN_IDLE;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlbreg_ctl.sv
module tlbreg_ctl
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 32,
  parameter int TID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_level,
  input  logic [1:0]        cfg_access,
  input  logic              cur_user,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              lk_valid,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [WORD_W-1:0] lk_vaddr,
  output logic [WORD_W-1:0] lk_tag,
  output logic [WORD_W-1:0] lk_data,
  output logic [TID_W-1:0]  lk_tid,
  output logic [TID_W-1:0]  lk_pid,
  output logic [WORD_W-1:0] lk_zpr,
  output logic              lk_user,
  input  logic              lk_hit,
  output logic              inval_valid,
  output logic [IDX_W-1:0]  inval_idx,
  output logic [WORD_W-1:0] inval_tag,
  output logic              flush_pulse
);

  localparam int MISS_BIT = WORD_W - 1;
  localparam logic [WORD_W-1:0] EPN_MASK = {{(WORD_W-EPN_LSB){1'b1}}, {EPN_LSB{1'b0}}};

  // architectural registers
  logic [WORD_W-1:0] index_q;
  logic [TID_W-1:0]  pid_q;
  logic [WORD_W-1:0] zone_q;
  logic [WORD_W-1:0] vaddr_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              inval_valid_q;
  logic [IDX_W-1:0]  inval_idx_q;
  logic [WORD_W-1:0] inval_tag_q;
  logic              flush_q;

  // request decode
  logic rd_ok, wr_ok;
  logic fire, rd_fire, wr_go;
  logic tag_we, data_we, owner_chg, search_go, tag_rd, zone_go;
  logic [IDX_W-1:0] sel_idx;
  logic [WORD_W-1:0] rd_word;

  // storage and scan
  logic [WORD_W-1:0] bus_tag, bus_data, scan_tag, scan_data;
  logic [TID_W-1:0]  bus_tid, scan_tid;
  scan_mode_e        mode;
  logic [IDX_W-1:0]  cnt;
  logic              scan_busy, hit_now, miss_now, inval_now;

  tlbreg_access u_access (
    .cfg_level  (cfg_level),
    .cfg_access (cfg_access),
    .addr       (req_addr),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok)
  );

  always_comb begin
    sel_idx   = index_q[IDX_W-1:0];
    fire      = req_valid && req_ready;
    rd_fire   = fire && !req_write;
    wr_go     = fire && req_write && wr_ok;
    tag_we    = wr_go && (req_addr == RA_TAG);
    data_we   = wr_go && (req_addr == RA_DATA);
    zone_go   = wr_go && (req_addr == RA_ZONE);
    search_go = wr_go && (req_addr == RA_SEARCH);
    owner_chg = wr_go && (req_addr == RA_PID) && (req_wdata[TID_W-1:0] != pid_q);
    tag_rd    = rd_fire && rd_ok && (req_addr == RA_TAG);
  end

  always_comb begin
    case (req_addr)
      RA_INDEX: rd_word = index_q;
      RA_DATA:  rd_word = bus_data;
      RA_TAG:   rd_word = bus_tag;
      RA_PID:   rd_word = WORD_W'(pid_q);
      RA_ZONE:  rd_word = zone_q;
      default:  rd_word = '0;
    endcase
    if (!rd_ok) rd_word = '0;
  end

  tlbreg_store #(
    .ENTRIES (ENTRIES),
    .WORD_W  (WORD_W),
    .TID_W   (TID_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_tag    (tag_we),
    .wr_data   (data_we),
    .wr_idx    (sel_idx),
    .wr_word   (req_wdata),
    .wr_tid    (pid_q),
    .bus_idx   (sel_idx),
    .bus_tag   (bus_tag),
    .bus_data  (bus_data),
    .bus_tid   (bus_tid),
    .scan_idx  (cnt),
    .scan_tag  (scan_tag),
    .scan_data (scan_data),
    .scan_tid  (scan_tid)
  );

  tlbreg_scan #(
    .ENTRIES (ENTRIES),
    .TID_W   (TID_W)
  ) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_search (search_go),
    .start_owner  (owner_chg),
    .owner_before (pid_q),
    .lk_hit       (lk_hit),
    .ent_valid    (scan_tag[TAG_VALID_BIT]),
    .ent_tid      (scan_tid),
    .mode         (mode),
    .cnt          (cnt),
    .busy         (scan_busy),
    .hit_now      (hit_now),
    .miss_now     (miss_now),
    .inval_now    (inval_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q       <= '0;
      pid_q         <= '0;
      zone_q        <= '0;
      vaddr_q       <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_data_q    <= '0;
      inval_valid_q <= 1'b0;
      inval_idx_q   <= '0;
      inval_tag_q   <= '0;
      flush_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rd_fire;
      if (rd_fire) rsp_data_q <= rd_word;

      flush_q <= zone_go && (req_wdata != zone_q);
      if (zone_go) zone_q <= req_wdata;

      // index register: bus write, search hit, search miss
      if (wr_go && (req_addr == RA_INDEX)) begin
        index_q <= req_wdata;
      end else if (hit_now) begin
        index_q <= WORD_W'(cnt);
      end else if (miss_now) begin
        index_q[MISS_BIT] <= 1'b1;
      end

      // process ID: bus write that changes it, or owner copy from a tag read
      if (owner_chg) begin
        pid_q <= req_wdata[TID_W-1:0];
      end else if (tag_rd) begin
        pid_q <= bus_tid;
      end

      if (search_go) vaddr_q <= req_wdata & EPN_MASK;

      // invalidate requests: stale mapping on tag write, or owner scan match
      inval_valid_q <= (tag_we && bus_tag[TAG_VALID_BIT]) || inval_now;
      if (tag_we) begin
        inval_idx_q <= sel_idx;
        inval_tag_q <= bus_tag;
      end else if (inval_now) begin
        inval_idx_q <= cnt;
        inval_tag_q <= scan_tag;
      end
    end
  end

  assign req_ready   = !scan_busy;
  assign busy        = scan_busy;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_data_q;
  assign lk_valid    = (mode == SCAN_SEARCH);
  assign lk_idx      = cnt;
  assign lk_vaddr    = vaddr_q;
  assign lk_tag      = scan_tag;
  assign lk_data     = scan_data;
  assign lk_tid      = scan_tid;
  assign lk_pid      = pid_q;
  assign lk_zpr      = zone_q;
  assign lk_user     = cur_user;
  assign inval_valid = inval_valid_q;
  assign inval_idx   = inval_idx_q;
  assign inval_tag   = inval_tag_q;
  assign flush_pulse = flush_q;

endmodule

// File: rtl/tlbreg_ctl_chk.sv
module tlbreg_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_level,
  input logic [1:0]  cfg_access,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [2:0]  req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        busy,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic        inval_valid,
  input logic        flush_pulse
);

  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R13

  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid); // R13

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R11

  AST_FLUSH_FROM_ZONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(req_valid && req_ready && req_write && req_addr == 3'd4)); // R9

  AST_FLUSH_NEEDS_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(cfg_level >= 2'd2 && cfg_access > 2'd1)); // R7

  AST_LOOKUP_EPN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_vaddr[9:0] == 10'd0)); // R8

  AST_INVAL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> ($past(busy) || $past(req_valid && req_ready && req_write && req_addr == 3'd2))); // R5

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (cfg_level < 2'd2 || cfg_access == 2'd0))
      |=> (rsp_rdata == 32'd0)); // R2

endmodule

bind tlbreg_ctl tlbreg_ctl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_level   (cfg_level),
  .cfg_access  (cfg_access),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .busy        (busy),
  .lk_valid    (lk_valid),
  .lk_vaddr    (lk_vaddr),
  .inval_valid (inval_valid),
  .flush_pulse (flush_pulse)
);

// File: tb/tlbreg_ctl_tb_top.sv
module tlbreg_ctl_tb_top;

  localparam int N  = 16;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_level = 2'd2;
  logic [1:0]  cfg_access = 2'd3;
  logic        cur_user = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        busy;
  logic        lk_valid;
  logic [IW-1:0] lk_idx;
  logic [31:0] lk_vaddr, lk_tag, lk_data, lk_zpr;
  logic [7:0]  lk_tid, lk_pid;
  logic        lk_user;
  logic        lk_hit;
  logic        inval_valid;
  logic [IW-1:0] inval_idx;
  logic [31:0] inval_tag;
  logic        flush_pulse;

  always #2 clk = ~clk;

  tlbreg_ctl #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_access(cfg_access),
    .cur_user(cur_user), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_vaddr(lk_vaddr), .lk_tag(lk_tag),
    .lk_data(lk_data), .lk_tid(lk_tid), .lk_pid(lk_pid), .lk_zpr(lk_zpr),
    .lk_user(lk_user), .lk_hit(lk_hit), .inval_valid(inval_valid),
    .inval_idx(inval_idx), .inval_tag(inval_tag), .flush_pulse(flush_pulse)
  );

  // external comparator model: valid tag, page number match
  always_comb lk_hit = lk_valid && lk_tag[6] && (lk_tag[31:10] == lk_vaddr[31:10]);

  int n_checks = 0;
  int n_fail   = 0;
  logic [N-1:0] inval_mask = '0;

  logic        cap_rsp_valid, cap_inval, cap_flush, cap_busy, cap_ready;
  logic [31:0] cap_rdata, cap_inval_tag;
  logic [IW-1:0] cap_inval_idx;

  always @(negedge clk) if (rst_n && inval_valid) inval_mask[inval_idx] = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cap_rsp_valid = rsp_valid; cap_rdata = rsp_rdata;
    cap_inval = inval_valid; cap_inval_idx = inval_idx; cap_inval_tag = inval_tag;
    cap_flush = flush_pulse; cap_busy = busy; cap_ready = req_ready;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_op(1'b0, a, 32'd0);
    chk(tag, {31'd0, cap_rsp_valid}, 32'd1);
    chk(tag, cap_rdata, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // {write, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'h0000_0003, 32'h0},
    {1'b1, 3'd1, 32'hAAAA_0011, 32'h0},
    {1'b1, 3'd3, 32'h0000_0005, 32'h0},
    {1'b1, 3'd2, 32'h0001_2440, 32'h0},
    {1'b0, 3'd1, 32'h0,         32'hAAAA_0011},
    {1'b0, 3'd2, 32'h0,         32'h0001_2440},
    {1'b1, 3'd3, 32'h0000_0009, 32'h0},
    {1'b0, 3'd3, 32'h0,         32'h0000_0009},
    {1'b0, 3'd2, 32'h0,         32'h0001_2440},
    {1'b0, 3'd3, 32'h0,         32'h0000_0005},   // owner copied by tag read (R4)
    {1'b1, 3'd0, 32'h0000_0107, 32'h0},
    {1'b0, 3'd0, 32'h0,         32'h0000_0107},
    {1'b0, 3'd6, 32'h0,         32'h0},           // undefined address (R12)
    {1'b0, 3'd5, 32'h0,         32'h0},
    {1'b1, 3'd0, 32'h0000_0013, 32'h0},           // high index bits ignored (R3)
    {1'b0, 3'd1, 32'h0,         32'hAAAA_0011}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 inval", {31'd0, inval_valid}, 32'd0);
    chk("R1 flush", {31'd0, flush_pulse}, 32'd0);
    rd_chk("R1 index", 3'd0, 32'd0);
    rd_chk("R1 pid", 3'd3, 32'd0);
    rd_chk("R1 zone", 3'd4, 32'd0);
    rd_chk("R1 tag", 3'd2, 32'd0);

    // table walk (R3 R4 R12)
    inval_mask = '0;
    for (int v = 0; v < NV; v++) begin
      bus_op(VEC[v][67], VEC[v][66:64], VEC[v][63:32]);
      wait_idle();
      if (!VEC[v][67]) chk($sformatf("R3 R4 R12 table row %0d", v), cap_rdata, VEC[v][31:0]);
    end
    chk("R10 owner change 5->9 invalidates entry 3", {16'd0, inval_mask}, 32'h0000_0008);

    // R5 stale mapping invalidate
    bus_op(1'b1, 3'd0, 32'd3);
    bus_op(1'b1, 3'd2, 32'h0002_0440);
    chk("R5 inval pulse", {31'd0, cap_inval}, 32'd1);
    chk("R5 inval old tag", cap_inval_tag, 32'h0001_2440);
    chk("R5 inval idx", {28'd0, cap_inval_idx}, 32'd3);
    bus_op(1'b1, 3'd0, 32'd4);
    bus_op(1'b1, 3'd2, 32'h0002_0440);
    chk("R5 no inval for invalid old tag", {31'd0, cap_inval}, 32'd0);
    chk("R13 no rsp after write", {31'd0, cap_rsp_valid}, 32'd0);

    // R8 search hit: first of entries 3 and 4
    bus_op(1'b1, 3'd5, 32'h0002_07FF);
    wait_idle();
    rd_chk("R8 search hit lowest entry", 3'd0, 32'd3);
    bus_op(1'b1, 3'd0, 32'h0000_0025);
    bus_op(1'b1, 3'd5, 32'h7FFF_0000);
    chk("R11 busy after search", {31'd0, cap_busy}, 32'd1);
    chk("R11 ready low", {31'd0, cap_ready}, 32'd0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R11 miss busy length", cnt, N);
    rd_chk("R8 miss sets top bit keeps rest", 3'd0, 32'h8000_0025);

    // R10 owner scans
    inval_mask = '0;
    bus_op(1'b1, 3'd3, 32'd0);
    wait_idle();
    chk("R10 owner 5->0", {16'd0, inval_mask}, 32'h0000_0018);
    bus_op(1'b1, 3'd0, 32'd5);
    bus_op(1'b1, 3'd2, 32'h0003_0440);
    inval_mask = '0;
    bus_op(1'b1, 3'd3, 32'd7);
    wait_idle();
    chk("R10 zero owner never matches", {16'd0, inval_mask}, 32'd0);
    bus_op(1'b1, 3'd0, 32'd6);
    bus_op(1'b1, 3'd2, 32'h0000_0000);
    inval_mask = '0;
    bus_op(1'b1, 3'd3, 32'd9);
    wait_idle();
    chk("R10 invalid entry skipped", {16'd0, inval_mask}, 32'd0);
    bus_op(1'b1, 3'd3, 32'd9);
    chk("R10 same owner no scan", {31'd0, cap_busy}, 32'd0);

    // R9 zone flush
    bus_op(1'b1, 3'd4, 32'h0000_00F0);
    chk("R9 flush on change", {31'd0, cap_flush}, 32'd1);
    rd_chk("R9 zone readback", 3'd4, 32'h0000_00F0);
    bus_op(1'b1, 3'd4, 32'h0000_00F0);
    chk("R9 no flush on same value", {31'd0, cap_flush}, 32'd0);

    // R7 write rights
    cfg_access = 2'd1;
    bus_op(1'b1, 3'd3, 32'h33);
    rd_chk("R7 pid write refused", 3'd3, 32'd9);
    bus_op(1'b1, 3'd4, 32'h11);
    chk("R7 no flush when refused", {31'd0, cap_flush}, 32'd0);
    rd_chk("R7 zone write refused", 3'd4, 32'h0000_00F0);
    bus_op(1'b1, 3'd5, 32'h0002_0400);
    chk("R7 search refused", {31'd0, cap_busy}, 32'd0);
    rd_chk("R7 index unchanged", 3'd0, 32'd6);

    // R6 read rights
    cfg_access = 2'd2;
    rd_chk("R6 pid read blocked", 3'd3, 32'd0);
    rd_chk("R6 data read blocked", 3'd1, 32'd0);
    rd_chk("R6 index read allowed", 3'd0, 32'd6);
    rd_chk("R6 tag read blocked", 3'd2, 32'd0);
    cfg_access = 2'd3;
    rd_chk("R6 blocked tag read kept owner", 3'd3, 32'd9);

    // R2 global disable
    cfg_level = 2'd1;
    bus_op(1'b1, 3'd0, 32'h55);
    rd_chk("R2 level low read zero", 3'd0, 32'd0);
    cfg_level = 2'd2;
    rd_chk("R2 write ignored", 3'd0, 32'd6);
    cfg_access = 2'd0;
    rd_chk("R2 access zero read zero", 3'd4, 32'd0);
    cfg_access = 2'd3;

    // R12 undefined address
    bus_op(1'b1, 3'd7, 32'hFFFF_FFFF);
    rd_chk("R12 addr 7 reads zero", 3'd7, 32'd0);
    rd_chk("R12 index untouched", 3'd0, 32'd6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule